// File: doc/BRIEF.md
# Programmable Test Clock Generator

This block produces the test clock (TCK) for a JTAG test-bus master from the system clock. The mode is chosen by a 2-bit input. TCK can run all the time, run only while the sequencer asks for cycles, advance by one period for each host access, or stay parked.

In every running mode, an 8-bit ratio sets the TCK frequency. The generator also gives the sequencer a one-cycle strobe for each rising edge and each falling edge of TCK. The sequencer uses these to change TMS and outbound data after a falling edge and to sample inbound data after a rising edge.

TCK rests low. A new TCK period can start only at a decision point. A decision point is a cycle in which TCK is low and its low half is complete, or in which TCK is idle. The mode and the ratio are read at that decision point, so a change never produces a short pulse. Command decoding and data buffering are left to the surrounding logic.

Top module: `tckg_top`

## Requirements
- R1: While rst_ni is low, tck_o, tck_rise_o and tck_fall_o are all 0.
- R2: With ratio N on div_i, each TCK period lasts 2×(N+1) clock cycles, with N+1 cycles high followed by at least N+1 cycles low.
- R3: Mode 0 (free-running) starts a new period at every decision point, so TCK toggles without a break.
- R4: Mode 1 (gated) starts a period at a decision point only when run_i is 1 on that clock edge. Otherwise TCK stays low.
- R5: Once a period has started, it completes its high half and its low half even if run_i drops or the mode changes.
- R6: In mode 2 (stepped), each recorded step_i pulse launches exactly one TCK period. A step that arrives while a period is running, or in the same cycle as a launch, queues one more period. Several steps while one is already queued count as one.
- R7: A step_i pulse in a cycle where mode_i is not 2 is not recorded. Switching to mode 2 afterwards does not start a period. A queued step is discarded at any decision point where mode_i is not 2.
- R8: div_i is captured only at decision points. The high half and the next low half of a period both use the ratio captured when that period started, even if div_i changes in the meantime.
- R9: tck_rise_o is 1 for exactly the cycle in which tck_o has just gone from 0 to 1. tck_fall_o is 1 for exactly the cycle in which tck_o has just gone from 1 to 0. All three outputs are registered.
- R10: Mode 3 (hold) never starts a period. TCK stays low once any running period has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 free, 1 gated, 2 stepped, 3 hold |
| div_i | input | DIV_W | Ratio N: period is 2×(N+1) clocks |
| run_i | input | 1 | Gated-mode request from the sequencer |
| step_i | input | 1 | One-cycle host step pulse |
| tck_o | output | 1 | Test clock, rests low |
| tck_rise_o | output | 1 | Strobe: TCK rose at the last edge |
| tck_fall_o | output | 1 | Strobe: TCK fell at the last edge |

## Verification
Every decision is made on the clock edge that samples the inputs, and tck_o and both strobes change on that same edge. A run_i or mode change that is seen at a decision point therefore shows at the outputs one edge later. A step_i pulse is first registered, so it starts TCK two edges after it is applied when TCK is at rest. The bench drives its inputs on the falling clock edge. It steps a behavioural model on the rising edge and compares all three outputs on the next falling edge, so each result is checked in the cycle where it is due. Window counts of rises and high cycles cover the period lengths, the ignored steps and the stopped modes.

// File: rtl/tckg_pkg.sv
package tckg_pkg;
  typedef enum logic [1:0] {
    TCK_FREE  = 2'd0,
    TCK_GATED = 2'd1,
    TCK_STEP  = 2'd2,
    TCK_HOLD  = 2'd3
  } tck_mode_e;
endpackage

// File: rtl/tckg_half_cnt.sv
// Half-period down counter: expire_o when the current half is done or idle.
module tckg_half_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/tckg_step_hold.sv
// One-deep record of host step requests.
module tckg_step_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic step_mode_i,
  input  logic launch_i,
  input  logic drop_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~(launch_i | drop_i)) | (step_i & step_mode_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/tckg_edge_ctl.sv
module tckg_edge_ctl
  import tckg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tck_mode_e    mode_i,
  input  logic [W-1:0] div_i,
  input  logic         run_i,
  input  logic         pend_i,
  input  logic         expire_i,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         launch_o,
  output logic         drop_o,
  output logic [W-1:0] div_q_o,
  output logic         tck_o,
  output logic         rise_o,
  output logic         fall_o
);
  logic         tck_q, rise_q, fall_q;
  logic [W-1:0] div_q;
  logic         decide, want, start, stop;

  // decision point: low half complete (or idle) at rest level
  assign decide = ~tck_q & expire_i;
  assign stop   =  tck_q & expire_i;

  always_comb begin
    unique case (mode_i)
      TCK_FREE:  want = 1'b1;
      TCK_GATED: want = run_i;
      TCK_STEP:  want = pend_i;
      default:   want = 1'b0;
    endcase
  end

  assign start      = decide & want;
  assign load_o     = start | stop;
  assign load_val_o = start ? div_i : div_q;
  assign launch_o   = start & (mode_i == TCK_STEP);
  assign drop_o     = decide & (mode_i != TCK_STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      div_q  <= '0;
    end else begin
      if (start)     tck_q <= 1'b1;
      else if (stop) tck_q <= 1'b0;
      rise_q <= start;
      fall_q <= stop;
      if (decide)    div_q <= div_i;
    end
  end

  assign div_q_o = div_q;
  assign tck_o   = tck_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/tckg_top.sv
module tckg_top
  import tckg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             step_i,
  output logic             tck_o,
  output logic             tck_rise_o,
  output logic             tck_fall_o
);
  tck_mode_e        mode;
  logic             load, launch, drop, pend, expire;
  logic [DIV_W-1:0] load_val;
  logic [DIV_W-1:0] cur_div;

  assign mode = tck_mode_e'(mode_i);

  tckg_half_cnt #(.W(DIV_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

  tckg_step_hold u_step (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step_i),
    .step_mode_i (mode == TCK_STEP),
    .launch_i    (launch),
    .drop_i      (drop),
    .pend_o      (pend)
  );

  tckg_edge_ctl #(.W(DIV_W)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .div_i      (div_i),
    .run_i      (run_i),
    .pend_i     (pend),
    .expire_i   (expire),
    .load_o     (load),
    .load_val_o (load_val),
    .launch_o   (launch),
    .drop_o     (drop),
    .div_q_o    (cur_div),
    .tck_o      (tck_o),
    .rise_o     (tck_rise_o),
    .fall_o     (tck_fall_o)
  );
endmodule

// File: rtl/tckg_chk.sv
module tckg_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             run_i,
  input logic             tck_o,
  input logic             tck_rise_o,
  input logic             tck_fall_o,
  input logic [DIV_W-1:0] cur_div
);
  logic [DIV_W:0] hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_len <= '0;
    else if (!tck_o) hi_len <= '0;
    else             hi_len <= hi_len + 1'b1;
  end

  // R9
  rise_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_rise_o |-> (tck_o && !$past(tck_o)));

  // R9
  fall_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_fall_o |-> (!tck_o && $past(tck_o)));

  // R9
  edge_marked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_o != $past(tck_o)) |-> (tck_rise_o || tck_fall_o));

  // R4
  gated_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tck_o && mode_i == 2'd1 && !run_i) |=> !tck_o);

  // R10
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tck_o && mode_i == 2'd3) |=> !tck_o);

  // R2
  high_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tck_fall_o |-> (hi_len == ({1'b0, cur_div} + 1'b1)));
endmodule

bind tckg_top tckg_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .run_i      (run_i),
  .tck_o      (tck_o),
  .tck_rise_o (tck_rise_o),
  .tck_fall_o (tck_fall_o),
  .cur_div    (cur_div)
);

// File: tb/test_tckg_top.sv
`timescale 1ns/1ps
module test_tckg_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] div = 8'd0;
  logic       run = 1'b0;
  logic       step = 1'b0;
  logic       tck, rise, fall;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R1";
  int rcnt = 0;
  int hcnt = 0;

  always #2.5 clk = ~clk;

  tckg_top #(.DIV_W(8)) i_tckg_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .div_i(div),
    .run_i(run), .step_i(step), .tck_o(tck), .tck_rise_o(rise), .tck_fall_o(fall)
  );

  // behavioural reference: level, cycles left in half, latched ratio, queued step
  int m_tck, m_left, m_div, m_pend, m_rise, m_fall;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tck = 0; m_left = 0; m_div = 0; m_pend = 0; m_rise = 0; m_fall = 0;
    end else begin
      int go, np;
      np = m_pend;
      m_rise = 0; m_fall = 0;
      if (m_left > 0) m_left--;
      else if (m_tck == 1) begin
        m_tck = 0; m_left = m_div; m_fall = 1;
      end else begin
        go = (mode == 0) || (mode == 1 && run) || (mode == 2 && m_pend != 0);
        m_div = div;
        if (mode != 2 || go) np = 0;
        if (go) begin m_tck = 1; m_left = div; m_rise = 1; end
      end
      if (step && mode == 2) np = 1;
      m_pend = np;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, {tck, rise, fall}, {m_tck[0], m_rise[0], m_fall[0]});
      if (rise) rcnt++;
      if (tck) hcnt++;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {tck, rise, fall}, 0);
    rst_n = 1'b1;

    // R3 R2 R9: free running, ratio 0 then 2
    tag = "R3"; tick(20);
    div = 8'd2; tick(12);
    tag = "R2"; rcnt = 0; tick(60);
    check("R2", rcnt, 10);

    // R4: gated, no request, TCK parks low
    mode = 2'd1; tag = "R4"; tick(10);
    rcnt = 0; tick(20);
    check("R4", rcnt, 0);

    // R5 R8: one-cycle request, ratio changed while high
    div = 8'd3; tick(2);
    tag = "R5"; rcnt = 0; hcnt = 0;
    run = 1'b1; tick(1); run = 1'b0;
    tag = "R8"; div = 8'd0; tick(20);
    check("R5", rcnt, 1);
    check("R8", hcnt, 4);

    // R4: sustained request at ratio 0
    tag = "R4"; run = 1'b1; rcnt = 0; tick(20);
    check("R4", rcnt, 10);
    run = 1'b0; tick(6);

    // R7: step while not stepped mode, then switch
    tag = "R7"; mode = 2'd0; tick(3);
    step = 1'b1; tick(1); step = 1'b0;
    mode = 2'd2; rcnt = 0; tick(20);
    check("R7", rcnt, 0);

    // R6: isolated steps, then back-to-back steps
    tag = "R6"; rcnt = 0;
    for (int k = 0; k < 3; k++) begin
      step = 1'b1; tick(1); step = 1'b0; tick(12);
    end
    check("R6", rcnt, 3);
    rcnt = 0;
    step = 1'b1; tick(2); step = 1'b0; tick(20);
    check("R6", rcnt, 2);
    div = 8'd4; rcnt = 0; hcnt = 0;
    step = 1'b1; tick(1); step = 1'b0; tick(3);
    step = 1'b1; tick(1); step = 1'b0; tick(1);
    step = 1'b1; tick(1); step = 1'b0; tick(40);
    check("R6", rcnt, 2);
    check("R2", hcnt, 10);

    // R10: hold mode from free running
    mode = 2'd0; tag = "R3"; tick(15);
    mode = 2'd3; tag = "R10"; rcnt = 0; tick(30);
    check("R10", rcnt, 0);
    check("R10", tck, 0);

    // R1: reset mid-period
    mode = 2'd0; div = 8'd1; tag = "R3"; tick(5);
    rst_n = 1'b0; tag = "R1"; tick(2);
    check("R1", {tck, rise, fall}, 0);
    rst_n = 1'b1; tick(10);

    finish_run();
  end
endmodule